// File: doc/BRIEF.md
# Bus Cycle Decoder with Wait States

This block sits between a processor bus with a 24-bit physical address and the memory and peripheral chip selects. On each bus request it reads the low 24 address bits, picks exactly one select, and works out how long the cycle lasts. Bits above bit 23 are not decoded, so the map repeats every 16 MB. The space is cut into four 4 MB regions on bits 23..22. These are main RAM, fast peripherals, boot ROM, and slow peripherals. The region sets either a short or a long cycle.

Main RAM is split into an internal half and an expansion half. A static board strap can lengthen expansion-RAM cycles by one clock. After reset, a ROM overlay makes the RAM region answer as boot ROM. This lets the processor fetch its start-up code from address zero. Software ends the overlay by writing a control bit. When the cycle's count of clocks has elapsed, the block returns a single-clock data acknowledge. An address that has no device behind it still completes, on the long timing, and raises a no-device flag, so the bus never stalls.

Top module: `bus_cycle_decoder`

## Requirements
- R1: Address bits above bit 23 have no effect on the select chosen or on the cycle length.
- R2: With the overlay off, addresses 0x000000–0x1FFFFF assert `ram_int_sel`, and the cycle lasts FAST_CLKS clocks.
- R3: Addresses 0x200000–0x3FFFFF, with the overlay off, assert `ram_exp_sel`. The cycle lasts FAST_CLKS clocks plus one when `exp_wait_strap` is 1 at cycle start, and exactly FAST_CLKS when it is 0.
- R4: Addresses 0x400000–0x7FFFFF assert `fio_sel[k]`, where k = address bits 19..16, and the cycle lasts FAST_CLKS clocks.
- R5: Addresses 0x800000–0xBFFFFF assert `rom_sel` with a SLOW_CLKS cycle. The decode does not depend on transfer direction, so writes are not blocked.
- R6: Addresses 0xC00000–0xDFFFFF assert `slot_sel[s]`, where s = address bits 20..18 (each slot is a 256 KB window), and the cycle lasts SLOW_CLKS clocks.
- R7: Addresses 0xE00000–0xFFFFFF assert `nodev` instead of a device select, and still complete with a SLOW_CLKS cycle.
- R8: After reset the overlay is on. While it is on, the whole range 0x000000–0x3FFFFF asserts `rom_sel` with a SLOW_CLKS cycle. A clock with `ctl_we`=1 loads `ctl_lowmap`: a 1 turns the overlay off, and a 0 turns it back on.
- R9: At most one of the select outputs (including `nodev`) is high at any time, and all of them are low out of reset.
- R10: The clock edge that first samples `as_req` high is edge 0. `dtack` is then high for exactly one clock, in the cycle that follows edge L, where L is the cycle length.
- R11: Selects go low in the cycle after an edge that samples `as_req` low. A strobe withdrawn before the acknowledge ends the cycle with no `dtack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_req | input | 1 | Address strobe; held high by the master until it sees `dtack` |
| addr | input | ADDR_W | Bus address; only bits 23..0 are decoded |
| exp_wait_strap | input | 1 | Static strap: 1 adds one clock to expansion-RAM cycles |
| ctl_we | input | 1 | Write enable for the low-map control bit |
| ctl_lowmap | input | 1 | Value written: 1 ends the ROM overlay, 0 restores it |
| ram_int_sel | output | 1 | Internal RAM select |
| ram_exp_sel | output | 1 | Expansion RAM select |
| rom_sel | output | 1 | Boot ROM select |
| fio_sel | output | 16 | One-hot fast peripheral selects |
| slot_sel | output | 8 | One-hot expansion slot selects |
| nodev | output | 1 | No device decoded for this cycle |
| dtack | output | 1 | Single-clock data acknowledge |

## Verification
The bench builds the block with FAST_CLKS=3 and SLOW_CLKS=7. These short lengths let every region, all eight slots and several peripheral indices run inside a short run, with the exact acknowledge clock checked each time. Because the fast and slow lengths are far apart, and the strap adds one clock on top of 3, a mix-up of cycle class or a lost strap shows up as a count mismatch. ADDR_W is left at 32, so garbage in the upper byte can be driven to show that it is ignored.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int N_FIO  = 16;
    localparam int N_SLOT = 8;

    typedef enum logic [1:0] {
        CYC_FAST     = 2'd0,
        CYC_FAST_EXP = 2'd1,
        CYC_SLOW     = 2'd2
    } cyc_kind_e;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_RUN  = 2'd1,
        T_DONE = 2'd2
    } tstate_e;

    typedef struct packed {
        logic              ram_int;
        logic              ram_exp;
        logic              rom;
        logic [N_FIO-1:0]  fio;
        logic [N_SLOT-1:0] slot;
        logic              nodev;
    } sel_t;

endpackage

// File: rtl/bcd_overlay.sv
module bcd_overlay
    import bcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl_we,
    input  logic ctl_lowmap,
    output logic overlay_on
);
    logic lowmap_q;

    always_ff @(posedge clk) begin
        if (rst)         lowmap_q <= 1'b0;
        else if (ctl_we) lowmap_q <= ctl_lowmap;
    end

    assign overlay_on = ~lowmap_q;

    // R8: a control write decides the overlay state seen on the next clock
    p_ctl_write_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (overlay_on == !$past(ctl_lowmap)));

endmodule

// File: rtl/bcd_region_decode.sv
module bcd_region_decode
    import bcd_pkg::*;
(
    input  logic [23:0] a,
    input  logic        overlay_on,
    output sel_t        sel,
    output cyc_kind_e   kind
);
    logic [N_FIO-1:0]  fio_hit;
    logic [N_SLOT-1:0] slot_hit;
    logic              unused_lo;

    assign unused_lo = ^a[15:0];

    for (genvar g = 0; g < N_FIO; g++) begin : g_fio
        assign fio_hit[g] = (a[19:16] == 4'(g));
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        assign slot_hit[s] = (a[20:18] == 3'(s));
    end

    always_comb begin
        sel  = '0;
        kind = CYC_SLOW;
        unique case (a[23:22])
            2'b00: begin
                if (overlay_on) begin
                    sel.rom = 1'b1;
                    kind    = CYC_SLOW;
                end else if (a[21]) begin
                    sel.ram_exp = 1'b1;
                    kind        = CYC_FAST_EXP;
                end else begin
                    sel.ram_int = 1'b1;
                    kind        = CYC_FAST;
                end
            end
            2'b01: begin
                sel.fio = fio_hit;
                kind    = CYC_FAST;
            end
            2'b10: begin
                sel.rom = 1'b1;
                kind    = CYC_SLOW;
            end
            default: begin
                if (!a[21]) sel.slot  = slot_hit;
                else        sel.nodev = 1'b1;
                kind = CYC_SLOW;
            end
        endcase
    end

    // R9: the combinational decode itself never names two targets
    always_comb begin
        a_dec_onehot_r9: assert ($onehot0(sel) || $isunknown(a));
    end

endmodule

// File: rtl/bcd_wait_timer.sv
module bcd_wait_timer
    import bcd_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             as_req,
    input  logic [CNT_W-1:0] len,
    output logic             start,
    output logic             dtack
);
    tstate_e          st;
    logic [CNT_W-1:0] cnt;

    assign start = as_req && (st == T_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= T_IDLE;
            cnt   <= '0;
            dtack <= 1'b0;
        end else begin
            dtack <= 1'b0;
            unique case (st)
                T_IDLE: if (as_req) begin
                    st  <= T_RUN;
                    cnt <= len - 1'b1;
                end
                T_RUN: begin
                    if (!as_req) begin
                        st <= T_IDLE;
                    end else if (cnt == '0) begin
                        dtack <= 1'b1;
                        st    <= T_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: if (!as_req) st <= T_IDLE;
            endcase
        end
    end

    // R10: the acknowledge only ever follows a running cycle
    p_dtack_from_run_r10: assert property (@(posedge clk) disable iff (rst)
        dtack |-> ($past(st) == T_RUN));

    // R10: the acknowledge never lasts two clocks
    p_dtack_once_r10: assert property (@(posedge clk) disable iff (rst)
        dtack |=> !dtack);

endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder
    import bcd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int FAST_CLKS = 100,
    parameter int SLOW_CLKS = 250
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              as_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              exp_wait_strap,
    input  logic              ctl_we,
    input  logic              ctl_lowmap,
    output logic              ram_int_sel,
    output logic              ram_exp_sel,
    output logic              rom_sel,
    output logic [N_FIO-1:0]  fio_sel,
    output logic [N_SLOT-1:0] slot_sel,
    output logic              nodev,
    output logic              dtack
);
    localparam int CNT_W = $clog2(FAST_CLKS + SLOW_CLKS + 2);

    logic             overlay_on;
    sel_t             dec_sel;
    cyc_kind_e        dec_kind;
    logic [CNT_W-1:0] len;
    logic             start;
    sel_t             sel_q;

    if (ADDR_W > 24) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:24];
    end

    bcd_overlay u_ovl (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_lowmap (ctl_lowmap),
        .overlay_on (overlay_on)
    );

    bcd_region_decode u_dec (
        .a          (addr[23:0]),
        .overlay_on (overlay_on),
        .sel        (dec_sel),
        .kind       (dec_kind)
    );

    always_comb begin
        unique case (dec_kind)
            CYC_FAST:     len = CNT_W'(FAST_CLKS);
            CYC_FAST_EXP: len = CNT_W'(FAST_CLKS) + CNT_W'(exp_wait_strap);
            default:      len = CNT_W'(SLOW_CLKS);
        endcase
    end

    bcd_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .as_req (as_req),
        .len    (len),
        .start  (start),
        .dtack  (dtack)
    );

    always_ff @(posedge clk) begin
        if (rst)          sel_q <= '0;
        else if (!as_req) sel_q <= '0;
        else if (start)   sel_q <= dec_sel;
    end

    assign ram_int_sel = sel_q.ram_int;
    assign ram_exp_sel = sel_q.ram_exp;
    assign rom_sel     = sel_q.rom;
    assign fio_sel     = sel_q.fio;
    assign slot_sel    = sel_q.slot;
    assign nodev       = sel_q.nodev;

    // R9: never two selects at once on the outputs
    p_one_sel_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_int_sel, ram_exp_sel, rom_sel, fio_sel, slot_sel, nodev}));

    // R11: a strobe sampled low clears every select on the next clock
    p_sel_clear_r11: assert property (@(posedge clk) disable iff (rst)
        !as_req |=> ({ram_int_sel, ram_exp_sel, rom_sel, fio_sel, slot_sel, nodev} == '0));

    // R11: an acknowledge is only produced while the strobe was held
    p_dtack_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        dtack |-> $past(as_req));

    // R10: every acknowledge comes with a decoded target
    p_dtack_has_sel_r10: assert property (@(posedge clk) disable iff (rst)
        dtack |-> ({ram_int_sel, ram_exp_sel, rom_sel, fio_sel, slot_sel, nodev} != '0));

endmodule

// File: tb/sim_bus_cycle_decoder.sv
`timescale 1ns/1ps
module sim_bus_cycle_decoder;
    localparam int FAST = 3;
    localparam int SLOW = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_req = 1'b0;
    logic [31:0] addr = '0;
    logic        strap = 1'b0;
    logic        ctl_we = 1'b0;
    logic        ctl_lowmap = 1'b0;
    logic        ram_int_sel, ram_exp_sel, rom_sel, nodev, dtack;
    logic [15:0] fio_sel;
    logic [7:0]  slot_sel;

    int checks = 0;
    int fails  = 0;
    bit ovl_model = 1'b1;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_decoder #(.ADDR_W(32), .FAST_CLKS(FAST), .SLOW_CLKS(SLOW)) u0 (
        .clk(clk), .rst(rst), .as_req(as_req), .addr(addr),
        .exp_wait_strap(strap), .ctl_we(ctl_we), .ctl_lowmap(ctl_lowmap),
        .ram_int_sel(ram_int_sel), .ram_exp_sel(ram_exp_sel), .rom_sel(rom_sel),
        .fio_sel(fio_sel), .slot_sel(slot_sel), .nodev(nodev), .dtack(dtack)
    );

    // packed view: {ram_int, ram_exp, rom, fio[15:0], slot[7:0], nodev}
    function automatic logic [27:0] outs();
        return {ram_int_sel, ram_exp_sel, rom_sel, fio_sel, slot_sel, nodev};
    endfunction

    function automatic logic [27:0] want_sel(logic [31:0] a);
        logic [27:0] v = '0;
        logic [23:0] p = a[23:0];
        if (p < 24'h400000) begin
            if (ovl_model)              v[25] = 1'b1;
            else if (p < 24'h200000)    v[27] = 1'b1;
            else                        v[26] = 1'b1;
        end else if (p < 24'h800000)    v[9 + (p >> 16) % 16] = 1'b1;
        else if (p < 24'hC00000)        v[25] = 1'b1;
        else if (p < 24'hE00000)        v[1 + (p - 24'hC00000) / 24'h40000] = 1'b1;
        else                            v[0] = 1'b1;
        return v;
    endfunction

    function automatic int want_len(logic [31:0] a);
        logic [23:0] p = a[23:0];
        if (p < 24'h400000 && ovl_model) return SLOW;
        if (p < 24'h200000)              return FAST;
        if (p < 24'h400000)              return FAST + (strap ? 1 : 0);
        if (p < 24'h800000)              return FAST;
        return SLOW;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic run_cycle(string req, logic [31:0] a);
        int n = 0;
        logic [27:0] es = want_sel(a);
        int el = want_len(a);
        @(negedge clk);
        addr = a; as_req = 1'b1;
        while (n < 60) begin
            @(negedge clk);
            n++;
            if (dtack === 1'b1) break;
        end
        check({req, " R10 ack clock"}, n, el + 1);
        check({req, " select"}, {4'h0, outs()}, {4'h0, es});
        @(negedge clk);
        check({req, " R10 ack single"}, {31'h0, dtack}, 32'h0);
        as_req = 1'b0;
        @(negedge clk);
        check({req, " R11 clear"}, {4'h0, outs()}, 32'h0);
    endtask

    task automatic write_ctl(logic v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_lowmap = v;
        @(negedge clk);
        ctl_we = 1'b0;
        ovl_model = ~v;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset selects", {4'h0, outs()}, 32'h0);
        check("R10 reset dtack", {31'h0, dtack}, 32'h0);
    endtask

    task automatic t_overlay();
        run_cycle("R8 overlay low", 32'h0000_0100);
        run_cycle("R8 overlay exp", 32'h0030_0000);
        write_ctl(1'b1);
        run_cycle("R8 R2 after clear", 32'h0000_0100);
    endtask

    task automatic t_ram();
        run_cycle("R2 ram int top", 32'h001F_FFFE);
        strap = 1'b0;
        run_cycle("R3 exp strap off", 32'h0020_0000);
        strap = 1'b1;
        run_cycle("R3 exp strap on", 32'h003F_FFFE);
        run_cycle("R2 int strap on", 32'h0010_0000);
        strap = 1'b0;
    endtask

    task automatic t_fio();
        run_cycle("R4 fio 0", 32'h0040_0000);
        run_cycle("R4 fio 5", 32'h0055_1234);
        run_cycle("R4 fio 15", 32'h007F_FFFE);
        run_cycle("R1 R4 upper byte", 32'hA54A_0000);
    endtask

    task automatic t_rom();
        run_cycle("R5 rom low", 32'h0080_0000);
        run_cycle("R5 rom high", 32'h00BF_FFFE);
        run_cycle("R1 R5 upper byte", 32'hFF80_0010);
    endtask

    task automatic t_slots();
        for (int s = 0; s < 8; s++)
            run_cycle("R6 slot", 32'h00C0_0000 + s * 32'h0004_0000 + 32'h0003_FFFE);
    endtask

    task automatic t_nodev();
        run_cycle("R7 nodev low", 32'h00E0_0000);
        run_cycle("R7 nodev high", 32'h00FF_FFFE);
    endtask

    task automatic t_abort();
        bit seen = 1'b0;
        @(negedge clk);
        addr = 32'h00C0_0000; as_req = 1'b1;
        repeat (2) @(negedge clk);
        as_req = 1'b0;
        for (int k = 0; k < SLOW + 3; k++) begin
            @(negedge clk);
            if (dtack === 1'b1) seen = 1'b1;
        end
        check("R11 abort no ack", {31'h0, seen}, 32'h0);
        check("R11 abort clear", {4'h0, outs()}, 32'h0);
    endtask

    task automatic t_restore();
        write_ctl(1'b0);
        run_cycle("R8 overlay restored", 32'h0000_0004);
        write_ctl(1'b1);
        run_cycle("R8 R3 after second clear", 32'h0020_0010);
    endtask

    initial begin
        t_reset();
        t_overlay();
        t_ram();
        t_fio();
        t_rom();
        t_slots();
        t_nodev();
        t_abort();
        t_restore();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule